// File: doc/BRIEF.md
# Flash Program/Erase Control Interlock

This block sits between a processor-style write bus and a flash array model. Software uses it to run program and erase sequences. A control register holds three bits: an operation select (program or erase), a capture enable and a high-voltage enable. Once the capture enable is set, the next bus write that falls inside the flash address window is not sent to the array. Instead, its address and data are held in internal latches and driven to the array model. After that, software turns the high-voltage strobe on and off repeatedly to form its pulses. Pulse width, pulse count, margin pulses and the wait before verify are all timed in software. The block itself keeps no timing.

The interlocks protect a sequence that is in progress. The high-voltage enable can only be set once a capture is held. While the strobe is on, the capture enable cannot be cleared and the operation select cannot be changed. Clearing the capture enable while the strobe is off discards the capture, so the next sequence has to capture again.

The design is a four-state machine:
- IDLE: capture disabled.
- ARMED: capture enabled, nothing held yet.
- HELD: a capture is held.
- PULSE: the strobe is on.

Its transitions are:
- IDLE→ARMED: a control write with the capture bit set.
- ARMED→HELD: an array write inside the window.
- HELD→PULSE: a control write with both the capture bit and the high-voltage bit set.
- PULSE→HELD: a control write with the high-voltage bit clear.
- ARMED→IDLE and HELD→IDLE: a control write with the capture bit clear.

All other combinations keep the current state.

Top module: `flash_pe_ctl`

## Requirements
- R1: A synchronous active-high reset clears the operation select, the capture enable, the strobe, the captured-valid flag and both latches. After reset, the control register (address 0x10) and the status register (address 0x11) both read 0.
- R2: While the strobe is off, a write to the control register loads the operation select from data bit 0 (1 = erase, 0 = program). The value is driven on `pe_erase` and reads back in control bit 0 in the following cycle.
- R3: With the capture enable set (control bit 1) and no capture held, a write to an address in the window 0x80..0xBF captures that address and data. They appear on `pe_addr` and `pe_data` in the following cycle, and the valid flag (status bit 0) reads 1.
- R4: A control write with bit 2 set turns the strobe on only if, before the write, the capture enable was set and a capture was held, and the same write keeps bit 1 set. Otherwise control bit 2 and `pe_hv_on` stay 0.
- R5: While the strobe is on, control bit 2 and `pe_hv_on` read 1. A control write with bit 2 clear turns the strobe off in the following cycle, and the capture stays held.
- R6: While the strobe is on, a control write with bit 1 clear leaves the capture enable set.
- R7: While the strobe is on, a control write leaves the operation select unchanged.
- R8: While the strobe is off, a control write with bit 1 clear clears the capture enable and the valid flag.
- R9: While a capture is held, further writes inside the window leave `pe_addr`, `pe_data` and the valid flag unchanged.
- R10: Writes outside the window are never captured and do not set the valid flag.
- R11: The status register is read-only. A write to it changes no control bit and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW (8) | Write and read address |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Combinational read data for `bus_addr` (0x10 control, 0x11 status, others 0) |
| pe_addr | output | AW (8) | Latched address to the array model |
| pe_data | output | DW (8) | Latched data to the array model |
| pe_erase | output | 1 | Operation select: 1 erase, 0 program |
| pe_hv_on | output | 1 | High-voltage strobe |

## Verification
The assertions assume the following about the inputs:
- Each write lasts exactly one cycle.
- Reset is applied before any check counts.
- The control and status addresses lie outside the flash window, so a single write is never both a register write and an array write.

The stimulus respects these assumptions. It drives each write as a single-cycle strobe between falling edges, always starts from a reset, and uses the default address map. The address sweep writes to the two register addresses as ordinary bus writes, never as array writes.

// File: rtl/flash_pe_pkg.sv
`timescale 1ns/1ps
package flash_pe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2,
        ST_PULSE = 2'd3
    } pe_state_t;

    localparam int unsigned CB_ERASE = 0;
    localparam int unsigned CB_LATCH = 1;
    localparam int unsigned CB_HV    = 2;
    localparam int unsigned SB_VALID = 0;
endpackage

// File: rtl/flash_pe_decode.sv
`timescale 1ns/1ps
module flash_pe_decode #(
    parameter int unsigned AW         = 8,
    parameter int unsigned CTL_ADDR   = 'h10,
    parameter int unsigned STAT_ADDR  = 'h11,
    parameter int unsigned FLASH_BASE = 'h80,
    parameter int unsigned FLASH_SIZE = 64
) (
    input  logic [AW-1:0] addr,
    output logic          ctl_hit,
    output logic          stat_hit,
    output logic          win_hit
);
    localparam logic [AW:0] WIN_LO = (AW+1)'(FLASH_BASE);
    localparam logic [AW:0] WIN_HI = (AW+1)'(FLASH_BASE + FLASH_SIZE);

    logic [AW:0] addr_x;

    always_comb begin
        addr_x   = {1'b0, addr};
        ctl_hit  = (addr == AW'(CTL_ADDR));
        stat_hit = (addr == AW'(STAT_ADDR));
        win_hit  = (addr_x >= WIN_LO) && (addr_x < WIN_HI);
    end
endmodule

// File: rtl/flash_pe_latch.sv
`timescale 1ns/1ps
module flash_pe_latch #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (cap_en) begin
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end
endmodule

// File: rtl/flash_pe_fsm.sv
`timescale 1ns/1ps
module flash_pe_fsm
    import flash_pe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr,
    input  logic arr_wr,
    input  logic w_erase,
    input  logic w_latch,
    input  logic w_hv,
    output logic erase,
    output logic lat_on,
    output logic hv_on,
    output logic cap_valid,
    output logic cap_en
);
    pe_state_t st_q, st_n;
    logic      erase_q, erase_n;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            erase_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            erase_q <= erase_n;
        end
    end

    // Transitions
    always_comb begin
        st_n    = st_q;
        erase_n = erase_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ctl_wr) begin
                    erase_n = w_erase;
                    if (w_latch) st_n = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (ctl_wr) begin
                    erase_n = w_erase;
                    if (!w_latch) st_n = ST_IDLE;
                end else if (arr_wr) begin
                    st_n = ST_HELD;
                end
            end
            ST_HELD: begin
                if (ctl_wr) begin
                    erase_n = w_erase;
                    if (!w_latch)  st_n = ST_IDLE;
                    else if (w_hv) st_n = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (ctl_wr && !w_hv) st_n = ST_HELD;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        erase     = erase_q;
        lat_on    = (st_q != ST_IDLE);
        hv_on     = (st_q == ST_PULSE);
        cap_valid = (st_q == ST_HELD) || (st_q == ST_PULSE);
        cap_en    = (st_q == ST_ARMED) && arr_wr && !ctl_wr;
    end
endmodule

// File: rtl/flash_pe_ctl.sv
`timescale 1ns/1ps
module flash_pe_ctl
    import flash_pe_pkg::*;
#(
    parameter int unsigned AW         = 8,
    parameter int unsigned DW         = 8,
    parameter int unsigned CTL_ADDR   = 'h10,
    parameter int unsigned STAT_ADDR  = 'h11,
    parameter int unsigned FLASH_BASE = 'h80,
    parameter int unsigned FLASH_SIZE = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] pe_addr,
    output logic [DW-1:0] pe_data,
    output logic          pe_erase,
    output logic          pe_hv_on
);
    logic ctl_hit, stat_hit, win_hit;
    logic lat_on, cap_valid, cap_en;
    logic ctl_wr, arr_wr;

    flash_pe_decode #(
        .AW(AW), .CTL_ADDR(CTL_ADDR), .STAT_ADDR(STAT_ADDR),
        .FLASH_BASE(FLASH_BASE), .FLASH_SIZE(FLASH_SIZE)
    ) u_dec (
        .addr(bus_addr), .ctl_hit(ctl_hit), .stat_hit(stat_hit), .win_hit(win_hit)
    );

    assign ctl_wr = bus_wr && ctl_hit;
    assign arr_wr = bus_wr && win_hit;

    flash_pe_fsm u_fsm (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .arr_wr(arr_wr),
        .w_erase(bus_wdata[CB_ERASE]), .w_latch(bus_wdata[CB_LATCH]),
        .w_hv(bus_wdata[CB_HV]),
        .erase(pe_erase), .lat_on(lat_on), .hv_on(pe_hv_on),
        .cap_valid(cap_valid), .cap_en(cap_en)
    );

    flash_pe_latch #(.AW(AW), .DW(DW)) u_lat (
        .clk(clk), .rst(rst), .cap_en(cap_en),
        .addr_in(bus_addr), .data_in(bus_wdata),
        .addr_q(pe_addr), .data_q(pe_data)
    );

    always_comb begin
        bus_rdata = '0;
        if (ctl_hit) begin
            bus_rdata[CB_ERASE] = pe_erase;
            bus_rdata[CB_LATCH] = lat_on;
            bus_rdata[CB_HV]    = pe_hv_on;
        end else if (stat_hit) begin
            bus_rdata[SB_VALID] = cap_valid;
        end
    end
endmodule

// File: rtl/flash_pe_ctl_chk.sv
`timescale 1ns/1ps
module flash_pe_ctl_chk #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          ctl_hit,
    input logic          win_hit,
    input logic          lat_on,
    input logic          cap_valid,
    input logic [AW-1:0] pe_addr,
    input logic [DW-1:0] pe_data,
    input logic          pe_erase,
    input logic          pe_hv_on
);
    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        lat_on && !cap_valid && bus_wr && win_hit && !ctl_hit
        |=> cap_valid && pe_addr == $past(bus_addr) && pe_data == $past(bus_wdata));

    a_r4_hv_needs_capture: assert property (@(posedge clk) disable iff (rst)
        bus_wr && ctl_hit && !pe_hv_on && !cap_valid |=> !pe_hv_on);

    a_r6_latch_held: assert property (@(posedge clk) disable iff (rst)
        pe_hv_on && bus_wr && ctl_hit && !bus_wdata[1] |=> lat_on);

    a_r7_erase_frozen: assert property (@(posedge clk) disable iff (rst)
        pe_hv_on |=> $stable(pe_erase));

    a_r8_discard: assert property (@(posedge clk) disable iff (rst)
        bus_wr && ctl_hit && !pe_hv_on && !bus_wdata[1] |=> !cap_valid && !lat_on);

    a_r9_single_capture: assert property (@(posedge clk) disable iff (rst)
        cap_valid && $past(cap_valid) |-> $stable(pe_addr) && $stable(pe_data));

    a_r10_outside_window: assert property (@(posedge clk) disable iff (rst)
        !cap_valid && bus_wr && !win_hit |=> !cap_valid);
endmodule

bind flash_pe_ctl flash_pe_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctl_hit(ctl_hit), .win_hit(win_hit),
    .lat_on(lat_on), .cap_valid(cap_valid), .pe_addr(pe_addr),
    .pe_data(pe_data), .pe_erase(pe_erase), .pe_hv_on(pe_hv_on)
);

// File: tb/flash_pe_ctl_test.sv
`timescale 1ns/1ps
module flash_pe_ctl_test;
    localparam logic [7:0] CTL  = 8'h10;
    localparam logic [7:0] STAT = 8'h11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, pe_addr, pe_data;
    logic       pe_erase, pe_hv_on;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    flash_pe_ctl uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pe_addr(pe_addr),
        .pe_data(pe_data), .pe_erase(pe_erase), .pe_hv_on(pe_hv_on)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bus_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // s: 0 idle, 1 armed, 2 held, 3 pulse
    task automatic go_state(input int s, input logic e);
        do_reset();
        wr(CTL, {7'd0, e});
        if (s >= 1) wr(CTL, {6'd0, 1'b1, e});
        if (s >= 2) wr(8'h85, 8'hA5);
        if (s >= 3) wr(CTL, {5'd0, 1'b1, 1'b1, e});
    endtask

    initial begin
        logic [7:0] r;
        do_reset();
        // R1 reset state
        rd(CTL, r);  check("R1 ctl after reset", r, 0);
        rd(STAT, r); check("R1 stat after reset", r, 0);
        check("R1 pe_hv_on after reset", pe_hv_on, 0);
        check("R1 pe_addr after reset", pe_addr, 0);
        check("R1 pe_data after reset", pe_data, 0);

        // Sweep: every state x operation select x every control write value
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 2; e++) begin
                for (int w = 0; w < 8; w++) begin
                    bit hv, lat, vld, er, ehv, elat, evld, eer;
                    hv = (s == 3); lat = (s >= 1); vld = (s >= 2); er = e[0];
                    go_state(s, e[0]);
                    wr(CTL, 8'(w));
                    if (hv) begin
                        eer = er; elat = 1'b1; evld = vld; ehv = w[2];
                    end else begin
                        eer = w[0]; elat = w[1];
                        evld = w[1] ? vld : 1'b0;
                        ehv = w[1] & lat & vld & w[2];
                    end
                    rd(CTL, r);
                    check(hv ? "R6 R7 R5 ctl readback in pulse" : "R2 R4 R8 ctl readback",
                          r, {ehv, elat, eer});
                    rd(STAT, r);
                    check(hv ? "R5 valid kept" : "R8 valid flag", r, evld);
                    check("R5 R4 pe_hv_on", pe_hv_on, ehv);
                    check("R7 R2 pe_erase", pe_erase, eer);
                    if (evld) check("R5 R9 pe_addr kept", pe_addr, 8'h85);
                end
            end
        end

        // Address sweep: capture window, first capture only, read-only status
        for (int a = 0; a < 256; a++) begin
            bit inwin;
            inwin = (a >= 8'h80) && (a < 8'hC0);
            do_reset();
            wr(CTL, 8'h02);
            wr(8'(a), 8'(a) ^ 8'h5A);
            rd(STAT, r);
            check(inwin ? "R3 capture valid" : "R10 outside not captured", r, inwin);
            if (inwin) begin
                check("R3 pe_addr", pe_addr, a);
                check("R3 pe_data", pe_data, (a ^ 8'h5A) & 8'hFF);
                wr(8'(((a + 1) % 64) + 8'h80), 8'h33);
                check("R9 pe_addr after second write", pe_addr, a);
                check("R9 pe_data after second write", pe_data, (a ^ 8'h5A) & 8'hFF);
                rd(STAT, r); check("R9 valid after second write", r, 1);
            end
            if (a == 8'h11) begin
                rd(CTL, r); check("R11 status write leaves ctl", r, 2);
            end
        end

        // R11: writing ones to the status register while held
        go_state(2, 1'b0);
        wr(STAT, 8'hFF);
        rd(CTL, r);  check("R11 ctl unchanged", r, 3'b010);
        rd(STAT, r); check("R11 stat unchanged", r, 1);

        // R1: reset in the middle of a pulse
        go_state(3, 1'b1);
        do_reset();
        check("R1 hv cleared by reset", pe_hv_on, 0);
        rd(CTL, r);  check("R1 ctl cleared mid-pulse", r, 0);
        rd(STAT, r); check("R1 stat cleared mid-pulse", r, 0);
        check("R1 pe_addr cleared", pe_addr, 0);

        // R5 repeated pulses: set and clear strobe, capture stays held
        go_state(2, 1'b1);
        for (int p = 0; p < 3; p++) begin
            wr(CTL, 8'h07);
            check("R5 strobe on", pe_hv_on, 1);
            wr(CTL, 8'h03);
            check("R5 strobe off", pe_hv_on, 0);
            rd(STAT, r); check("R5 valid held across pulses", r, 1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule